// File: doc/BRIEF.md
# Set/Clear Global Interrupt Enable Register

This block is a 16-bit control register holding two global interrupt enable flags for a bus controller. One flag gates requests raised when software touches an address that has no memory behind it; the other gates requests raised when software writes somewhere it may not, such as a staging buffer. Software never writes a flag value directly. Each flag owns a set control bit and a clear control bit in the written word. A flag changes only when exactly one of its two controls is 1, so software can change one flag without first reading the register.

The register sits behind a simple synchronous slave port. A write takes effect only when the block is selected, the write strobe is high and the access is a full 16-bit word. Read data reflects the two flags continuously. Each event input is ANDed with its flag and registered to form an interrupt request. An event that meets a cleared flag is lost; it is not held pending.

Top module: `glob_irq_enable_reg`

## Requirements
- R1: While and right after the synchronous active-low reset, both flags read 0 and both interrupt request outputs are 0.
- R2: A qualifying write with bit 9 = 1 and bit 1 = 0 sets the bad-address flag, which reads back at bit 1 from the cycle after the write edge.
- R3: A qualifying write with bit 9 = 0 and bit 1 = 1 clears the bad-address flag.
- R4: A qualifying write with bits 9 and 1 both 0 or both 1 leaves the bad-address flag unchanged.
- R5: A qualifying write with bit 10 = 1 and bit 2 = 0 sets the bad-write flag, which reads back at bit 2.
- R6: A qualifying write with bit 10 = 0 and bit 2 = 1 clears the bad-write flag.
- R7: A qualifying write with bits 10 and 2 both 0 or both 1 leaves the bad-write flag unchanged.
- R8: The control bits of one flag never change the other flag.
- R9: A write is qualifying only when sel, wr_en and wr_word are all 1. Any other write attempt changes neither flag.
- R10: Every read data bit other than bits 1 and 2 is always 0.
- R11: Each request output is high in the cycle after its event input is sampled high while its flag is 1. It is low otherwise. An event seen with the flag at 0 never produces a later request.
- R12: When a write and an event arrive at the same edge, the request uses the flag value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sel | input | 1 | Register select from the address decoder |
| wr_en | input | 1 | Write strobe |
| wr_word | input | 1 | 1 = full 16-bit access, 0 = narrower access (ignored) |
| wdata | input | 16 | Write data carrying set/clear control pairs |
| rdata | output | 16 | Read data: bad-address flag at bit 1, bad-write flag at bit 2 |
| ev_bad_addr | input | 1 | Event: access to an unavailable address |
| ev_bad_write | input | 1 | Event: invalid write access |
| irq_bad_addr | output | 1 | Registered, gated bad-address interrupt request |
| irq_bad_write | output | 1 | Registered, gated bad-write interrupt request |

## Verification
A corrupted flag is visible on rdata in the cycle after the write edge that produced it. The same flag also shows on the matching request output one cycle after the next event. The directed scenarios therefore read back after every write, across all four control combinations for each flag. Read-back with flags set and cleared in opposite patterns exposes any crosstalk between flags, or a decode on the wrong bit, at once. The request timing is checked at the edge where a write and an event coincide, because that is where an off-by-one in the enable source shows.

// File: rtl/gie_pkg.sv
`timescale 1ns/1ps
package gie_pkg;
    localparam int DATA_W  = 16;
    localparam int NUM_EN  = 2;

    // Index 0: bad-address flag, index 1: bad-write flag.
    // Set control positions in the written word.
    localparam int SET_POS [NUM_EN] = '{9, 10};
    // Clear control positions; these are also the read-back positions.
    localparam int CLR_POS [NUM_EN] = '{1, 2};

    typedef struct packed {
        logic [NUM_EN-1:0] en;
        logic [NUM_EN-1:0] irq;
    } gie_state_t;
endpackage

// File: rtl/gie_access_qual.sv
`timescale 1ns/1ps
module gie_access_qual (
    input  logic sel,
    input  logic wr_en,
    input  logic wr_word,
    output logic wr_fire
);
    // Only full-word selected writes reach the flags.
    always_comb begin
        wr_fire = sel & wr_en & wr_word;
    end
endmodule

// File: rtl/gie_flag_cell.sv
`timescale 1ns/1ps
module gie_flag_cell (
    input  logic wr_fire,
    input  logic set_bit,
    input  logic clr_bit,
    input  logic cur,
    output logic nxt
);
    always_comb begin
        nxt = cur;
        if (wr_fire) begin
            unique case ({set_bit, clr_bit})
                2'b10:   nxt = 1'b1;
                2'b01:   nxt = 1'b0;
                default: nxt = cur;
            endcase
        end
    end
endmodule

// File: rtl/glob_irq_enable_reg.sv
`timescale 1ns/1ps
module glob_irq_enable_reg
    import gie_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr_en,
    input  logic              wr_word,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              ev_bad_addr,
    input  logic              ev_bad_write,
    output logic              irq_bad_addr,
    output logic              irq_bad_write
);
    gie_state_t        state_d, state_q;
    logic              wr_fire;
    logic [NUM_EN-1:0] en_nxt;
    logic [NUM_EN-1:0] ev_vec;

    assign ev_vec = {ev_bad_write, ev_bad_addr};

    gie_access_qual u_qual (
        .sel     (sel),
        .wr_en   (wr_en),
        .wr_word (wr_word),
        .wr_fire (wr_fire)
    );

    for (genvar g = 0; g < NUM_EN; g++) begin : g_flag
        gie_flag_cell u_cell (
            .wr_fire (wr_fire),
            .set_bit (wdata[SET_POS[g]]),
            .clr_bit (wdata[CLR_POS[g]]),
            .cur     (state_q.en[g]),
            .nxt     (en_nxt[g])
        );
    end

    // Next-state: enables from the cells, requests gated by the current enables.
    always_comb begin
        state_d     = state_q;
        state_d.en  = en_nxt;
        state_d.irq = ev_vec & state_q.en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_EN; i++) begin
            rdata[CLR_POS[i]] = state_q.en[i];
        end
    end

    assign irq_bad_addr  = state_q.irq[0];
    assign irq_bad_write = state_q.irq[1];
endmodule

// File: rtl/glob_irq_enable_reg_chk.sv
`timescale 1ns/1ps
module glob_irq_enable_reg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sel,
    input logic        wr_en,
    input logic        wr_word,
    input logic [15:0] wdata,
    input logic [15:0] rdata,
    input logic        ev_bad_addr,
    input logic        ev_bad_write,
    input logic        irq_bad_addr,
    input logic        irq_bad_write
);
    logic fire;
    assign fire = sel & wr_en & wr_word;

    assert_set_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && wdata[9] && !wdata[1]) |=> rdata[1]);
    assert_clr_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !wdata[9] && wdata[1]) |=> !rdata[1]);
    assert_hold_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && (wdata[9] == wdata[1])) |=> $stable(rdata[1]));
    assert_set_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && wdata[10] && !wdata[2]) |=> rdata[2]);
    assert_clr_wr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !wdata[10] && wdata[2]) |=> !rdata[2]);
    assert_hold_wr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && (wdata[10] == wdata[2])) |=> $stable(rdata[2]));
    assert_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(rdata[2:1]));
    assert_zero_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata & 16'hFFF9) == 16'h0000);
    assert_irq_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_bad_addr == $past(ev_bad_addr && rdata[1])));
    assert_irq_wr_R12: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_bad_write == $past(ev_bad_write && rdata[2])));
endmodule

bind glob_irq_enable_reg glob_irq_enable_reg_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .sel           (sel),
    .wr_en         (wr_en),
    .wr_word       (wr_word),
    .wdata         (wdata),
    .rdata         (rdata),
    .ev_bad_addr   (ev_bad_addr),
    .ev_bad_write  (ev_bad_write),
    .irq_bad_addr  (irq_bad_addr),
    .irq_bad_write (irq_bad_write)
);

// File: tb/glob_irq_enable_reg_tb_top.sv
`timescale 1ns/1ps
module glob_irq_enable_reg_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_word = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        ev_bad_addr = 1'b0;
    logic        ev_bad_write = 1'b0;
    logic        irq_bad_addr;
    logic        irq_bad_write;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    glob_irq_enable_reg dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .sel           (sel),
        .wr_en         (wr_en),
        .wr_word       (wr_word),
        .wdata         (wdata),
        .rdata         (rdata),
        .ev_bad_addr   (ev_bad_addr),
        .ev_bad_write  (ev_bad_write),
        .irq_bad_addr  (irq_bad_addr),
        .irq_bad_write (irq_bad_write)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge capture, return at the next falling edge.
    task automatic bus_wr(input logic [15:0] d, input logic s = 1'b1,
                          input logic w = 1'b1, input logic full = 1'b1);
        @(negedge clk);
        sel = s; wr_en = w; wr_word = full; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr_en = 1'b0; wr_word = 1'b0; wdata = '0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        sel = 1'b1; wr_en = 1'b1; wr_word = 1'b1; wdata = 16'h0600;
        ev_bad_addr = 1'b1; ev_bad_write = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 rdata in reset", rdata, 16'h0000);
        chk("R1 irqs in reset", {14'd0, irq_bad_write, irq_bad_addr}, 16'h0000);
        sel = 1'b0; wr_en = 1'b0; wr_word = 1'b0; wdata = '0;
        ev_bad_addr = 1'b0; ev_bad_write = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rdata after reset", rdata, 16'h0000);
        chk("R1 irqs after reset", {14'd0, irq_bad_write, irq_bad_addr}, 16'h0000);
    endtask

    task automatic t_addr_flag();
        bus_wr(16'h0200); chk("R2 set bad-addr", rdata, 16'h0002);
        bus_wr(16'h0202); chk("R4 both-1 hold set", rdata, 16'h0002);
        bus_wr(16'h0000); chk("R4 both-0 hold set", rdata, 16'h0002);
        bus_wr(16'h0002); chk("R3 clear bad-addr", rdata, 16'h0000);
        bus_wr(16'h0202); chk("R4 both-1 hold clear", rdata, 16'h0000);
        bus_wr(16'h0000); chk("R4 both-0 hold clear", rdata, 16'h0000);
    endtask

    task automatic t_write_flag();
        bus_wr(16'h0400); chk("R5 set bad-write", rdata, 16'h0004);
        bus_wr(16'h0404); chk("R7 both-1 hold set", rdata, 16'h0004);
        bus_wr(16'h0000); chk("R7 both-0 hold set", rdata, 16'h0004);
        bus_wr(16'h0004); chk("R6 clear bad-write", rdata, 16'h0000);
        bus_wr(16'h0404); chk("R7 both-1 hold clear", rdata, 16'h0000);
    endtask

    task automatic t_cross();
        bus_wr(16'h0600); chk("R8 set both", rdata, 16'h0006);
        bus_wr(16'h0002); chk("R8 clear addr keeps write", rdata, 16'h0004);
        bus_wr(16'h0200); chk("R8 set addr keeps write", rdata, 16'h0006);
        bus_wr(16'h0004); chk("R8 clear write keeps addr", rdata, 16'h0002);
        bus_wr(16'h0400); chk("R8 set write keeps addr", rdata, 16'h0006);
    endtask

    task automatic t_other_bits();
        bus_wr(16'hFFFF); chk("R10 all-ones write", rdata, 16'h0006);
        bus_wr(16'hF9FF); chk("R10 clears with noise bits", rdata, 16'h0000);
        bus_wr(16'hFFF9); chk("R10 sets with noise bits", rdata, 16'h0006);
        bus_wr(16'h0006); chk("R10 clear both", rdata, 16'h0000);
    endtask

    task automatic t_qualify();
        bus_wr(16'h0600, 1'b1, 1'b1, 1'b0); chk("R9 narrow write ignored", rdata, 16'h0000);
        bus_wr(16'h0600, 1'b0, 1'b1, 1'b1); chk("R9 unselected ignored", rdata, 16'h0000);
        bus_wr(16'h0600, 1'b1, 1'b0, 1'b1); chk("R9 no strobe ignored", rdata, 16'h0000);
        bus_wr(16'h0600);
        bus_wr(16'h0006, 1'b1, 1'b1, 1'b0); chk("R9 narrow clear ignored", rdata, 16'h0006);
        bus_wr(16'h0006);
    endtask

    task automatic t_irq();
        bus_wr(16'h0200);
        @(negedge clk); ev_bad_addr = 1'b1; ev_bad_write = 1'b1;
        @(negedge clk); ev_bad_addr = 1'b0; ev_bad_write = 1'b0;
        chk("R11 gated requests", {14'd0, irq_bad_write, irq_bad_addr}, 16'h0001);
        @(negedge clk);
        chk("R11 requests fall", {14'd0, irq_bad_write, irq_bad_addr}, 16'h0000);
        bus_wr(16'h0400);
        @(negedge clk);
        chk("R11 dropped event not pending", {15'd0, irq_bad_write}, 16'h0000);
        @(negedge clk); ev_bad_write = 1'b1;
        @(negedge clk); ev_bad_write = 1'b0;
        chk("R11 enabled bad-write request", {15'd0, irq_bad_write}, 16'h0001);
        @(negedge clk);
        chk("R11 bad-write request falls", {15'd0, irq_bad_write}, 16'h0000);
    endtask

    task automatic t_same_cycle();
        // Both flags are 1 here. Clear bad-addr while its event arrives.
        @(negedge clk);
        sel = 1'b1; wr_en = 1'b1; wr_word = 1'b1; wdata = 16'h0002; ev_bad_addr = 1'b1;
        @(negedge clk);
        sel = 1'b0; wr_en = 1'b0; wr_word = 1'b0; wdata = '0;
        chk("R12 old enable used on clear", {15'd0, irq_bad_addr}, 16'h0001);
        chk("R12 flag cleared", rdata, 16'h0004);
        @(negedge clk); ev_bad_addr = 1'b0;
        chk("R12 next cycle uses new enable", {15'd0, irq_bad_addr}, 16'h0000);
        // Set bad-addr while its event arrives: old enable 0 gives no request.
        sel = 1'b1; wr_en = 1'b1; wr_word = 1'b1; wdata = 16'h0200; ev_bad_addr = 1'b1;
        @(negedge clk);
        sel = 1'b0; wr_en = 1'b0; wr_word = 1'b0; wdata = '0; ev_bad_addr = 1'b0;
        chk("R12 old enable used on set", {15'd0, irq_bad_addr}, 16'h0000);
        chk("R12 flag set", rdata, 16'h0006);
    endtask

    initial begin
        t_reset();
        t_addr_flag();
        t_write_flag();
        t_cross();
        t_other_bits();
        t_qualify();
        t_irq();
        t_same_cycle();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule